// File: doc/BRIEF.md
# Half-Integer Predivided Clock Generator

This block derives a programmable peripheral clock, such as a pixel clock or an audio master clock, from one of three source clocks. The source passes through a predivider that divides by 2, 2.5 or 3, and then through an integer divider. The overall ratio is the product of the two stages. Software controls everything through one 32-bit control word.

The block runs on a single fast system clock `clk`. Each source clock is presented as a half-cycle tick strobe: one `clk`-wide pulse on `srcHalfTick[i]` for every edge (rising or falling) of source `i`. Counting edges rather than cycles lets the divide-by-2.5 mode land exactly on a source edge. The outputs are `clkOut`, a registered divided clock free of glitches, and `clkEn`, a one-cycle strobe for each completed output period.

Control writes go to a shadow copy. The working configuration takes the shadow only at an output period boundary, or at once when the generator is stopped, so reprogramming never produces a runt pulse.

Top module: `frac_clkgen`

## Requirements
- R1: The output period equals the selected source period multiplied by the predivide ratio and by the integer divisor. In source edges this is 2 × ratio × divisor.
- R2: Predivider code 1 divides by 2 (4 source edges), code 2 divides by 2.5 (5 source edges), and code 3 divides by 3 (6 source edges).
- R3: When bit 14 is clear, source 0 is used and bit 13 is ignored. When bit 14 is set, bit 13 chooses source 1 (bit 13 clear) or source 2 (bit 13 set).
- R4: Control word layout: integer divisor in bits 6:0, predivider code in bits 9:8, source bits 13 and 14, run enable in bit 15. All other bits have no effect.
- R5: An integer divisor of 0 or 1 stops the generator: `clkOut` stays low and `clkEn` never pulses.
- R6: The fastest legal setting (code 1, divisor 2) gives an output period of exactly four source cycles, so the output never exceeds a quarter of the source rate.
- R7: Predivider code 0 stops the generator, with `clkOut` held low.
- R8: After the enable bit is cleared, `clkOut` goes low and `clkEn` stops within one output period.
- R9: A new control word written in the middle of a period takes effect only after that period completes with its old length.
- R10: In each period, `clkOut` is high for the first floor(divisor/2) predivided intervals and low for the rest. `clkEn` pulses for one `clk` cycle while `clkOut` is low, once per period.
- R11: During and after reset, both `clkOut` and `clkEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than every source edge rate |
| rstN | input | 1 | Active-low synchronous reset |
| srcHalfTick | input | 3 | Per-source strobe, one pulse per source clock edge |
| cfgWr | input | 1 | Write strobe for the control word |
| cfgData | input | 32 | Control word value |
| clkOut | output | 1 | Divided output clock |
| clkEn | output | 1 | One-cycle strobe per completed output period |

## Verification
The assertions assume that each tick strobe lasts a single `clk` cycle and that ticks of one source never come closer than one per `clk` cycle. That keeps every output period at least eight `clk` cycles, so `clkEn` can never pulse twice in a row. The stimulus drives every source from a free-running counter that emits one isolated tick every one, two or three cycles, with a different spacing per source. Control words are written only on the falling clock edge. This gives the exact periodic edge pattern from which the expected period and high time are computed.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int DIV_W    = 7;
  localparam int NUM_SRC  = 3;
  localparam int CFG_W    = 32;
  localparam int PRE_W    = 3;
  localparam int PDIV_LSB = 8;
  localparam int PSEL_BIT = 13;
  localparam int ESEL_BIT = 14;
  localparam int EN_BIT   = 15;

  typedef struct packed {
    logic             en;
    logic             esel;
    logic             psel;
    logic [1:0]       pdiv;
    logic [DIV_W-1:0] div;
  } cfg_t;

  typedef struct packed {
    logic run;
    logic clear;
  } ctrl_s;
endpackage

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             periodEnd,
  output cfg_t             activeCfg,
  output ctrl_s            ctrl
);
  cfg_t shadowCfg;
  cfg_t writeCfg;
  logic running;
  logic unusedCfgBits;

  assign unusedCfgBits = ^{cfgData[CFG_W-1:EN_BIT+1], cfgData[PSEL_BIT-1:PDIV_LSB+2],
                           cfgData[PDIV_LSB-1:DIV_W]};

  always_comb begin
    writeCfg.en   = cfgData[EN_BIT];
    writeCfg.esel = cfgData[ESEL_BIT];
    writeCfg.psel = cfgData[PSEL_BIT];
    writeCfg.pdiv = cfgData[PDIV_LSB+1:PDIV_LSB];
    writeCfg.div  = cfgData[DIV_W-1:0];
  end

  assign running = activeCfg.en && (activeCfg.pdiv != 2'd0) && (activeCfg.div >= DIV_W'(2));
  assign ctrl.run   = running;
  assign ctrl.clear = !running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCfg <= '0;
      activeCfg <= '0;
    end else begin
      if (cfgWr) shadowCfg <= writeCfg;
      if (!running || periodEnd) activeCfg <= shadowCfg;
    end
  end

  // R9
  cfg_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeCfg != $past(activeCfg)) |-> $past(periodEnd || !running));
endmodule

// File: rtl/clkgen_datapath.sv
module clkgen_datapath
  import clkgen_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcHalfTick,
  input  cfg_t               activeCfg,
  input  ctrl_s              ctrl,
  output logic               periodEnd,
  output logic               clkOut,
  output logic               clkEn
);
  logic             selTick;
  logic [PRE_W-1:0] halfLast;
  logic [PRE_W-1:0] preCnt;
  logic [DIV_W-1:0] intCnt;
  logic [DIV_W-1:0] intLast;
  logic [DIV_W-1:0] highLen;
  logic             preWrap;

  always_comb begin
    if (!activeCfg.esel) selTick = srcHalfTick[0];
    else if (!activeCfg.psel) selTick = srcHalfTick[1];
    else selTick = srcHalfTick[2];
  end

  always_comb begin
    case (activeCfg.pdiv)
      2'd1:    halfLast = PRE_W'(3);
      2'd2:    halfLast = PRE_W'(4);
      2'd3:    halfLast = PRE_W'(5);
      default: halfLast = '0;
    endcase
  end

  assign intLast   = activeCfg.div - DIV_W'(1);
  assign highLen   = activeCfg.div >> 1;
  assign preWrap   = selTick && (preCnt == halfLast);
  assign periodEnd = ctrl.run && preWrap && (intCnt == intLast);

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear) begin
      preCnt <= '0;
      intCnt <= '0;
    end else if (selTick) begin
      preCnt <= preWrap ? '0 : preCnt + PRE_W'(1);
      if (preWrap) intCnt <= (intCnt == intLast) ? '0 : intCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkOut <= 1'b0;
      clkEn  <= 1'b0;
    end else begin
      clkOut <= ctrl.run && (intCnt < highLen);
      clkEn  <= periodEnd;
    end
  end

  // R2
  pre_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.run |-> preCnt <= halfLast);
  // R1
  int_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.run |-> intCnt < activeCfg.div);
  // R10
  strobe_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |-> !clkOut);
  // R10
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |=> !clkEn);
endmodule

// File: rtl/frac_clkgen.sv
module frac_clkgen
  import clkgen_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcHalfTick,
  input  logic               cfgWr,
  input  logic [CFG_W-1:0]   cfgData,
  output logic               clkOut,
  output logic               clkEn
);
  cfg_t  activeCfg;
  ctrl_s ctrl;
  logic  periodEnd;

  clkgen_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData),
    .periodEnd(periodEnd), .activeCfg(activeCfg), .ctrl(ctrl)
  );

  clkgen_datapath u_dp (
    .clk(clk), .rstN(rstN), .srcHalfTick(srcHalfTick), .activeCfg(activeCfg),
    .ctrl(ctrl), .periodEnd(periodEnd), .clkOut(clkOut), .clkEn(clkEn)
  );

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rstN) |-> (!clkOut && !clkEn));
endmodule

// File: tb/frac_clkgen_bench.sv
module frac_clkgen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  srcHalfTick = '0;
  logic        cfgWr = 1'b0;
  logic [31:0] cfgData = '0;
  logic        clkOut;
  logic        clkEn;
  int checks = 0;
  int fails = 0;
  int tc0 = 0, tc1 = 0, tc2 = 0;
  int cyc = 0;
  bit done = 0;

  frac_clkgen u_frac_clkgen (
    .clk(clk), .rstN(rstN), .srcHalfTick(srcHalfTick),
    .cfgWr(cfgWr), .cfgData(cfgData), .clkOut(clkOut), .clkEn(clkEn)
  );

  always #5 clk = ~clk;

  // source 0 ticks every cycle, source 1 every 2, source 2 every 3
  always @(negedge clk) begin
    srcHalfTick[0] <= 1'b1;
    srcHalfTick[1] <= (tc1 == 0);
    srcHalfTick[2] <= (tc2 == 0);
    tc1 <= (tc1 + 1) % 2;
    tc2 <= (tc2 + 1) % 3;
    tc0 <= tc0 + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] mk(bit en, bit esel, bit psel, int pdiv, int dv);
    logic [31:0] w;
    w = '0;
    w[15] = en; w[14] = esel; w[13] = psel;
    w[9:8] = pdiv[1:0]; w[6:0] = dv[6:0];
    return w;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(logic [31:0] w);
    @(negedge clk);
    cfgWr = 1'b1; cfgData = w;
    @(negedge clk);
    cfgWr = 1'b0; cfgData = '0;
  endtask

  task automatic waitPulse(output bit seen);
    seen = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (clkEn) begin seen = 1; break; end
    end
  endtask

  // counts cycles from one strobe to the next, plus high cycles of clkOut
  task automatic measure(output int per, output int hi);
    per = 0; hi = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      per++;
      if (clkOut) hi++;
      if (clkEn) break;
    end
  endtask

  task automatic runCase(string req, logic [31:0] w, int expPer, int expHi);
    bit seen; int per; int hi;
    writeCfg(w);
    waitPulse(seen);
    waitPulse(seen);
    measure(per, hi);
    check(per == expPer, {req, " period"}, per, expPer);
    check(hi == expHi, {req, " high time"}, hi, expHi);
  endtask

  task automatic checkSilent(string req, int span);
    int highs = 0; int pulses = 0;
    for (int i = 0; i < span; i++) begin
      @(negedge clk);
      if (clkOut) highs++;
      if (clkEn) pulses++;
    end
    check(highs == 0, {req, " clkOut high cycles"}, highs, 0);
    check(pulses == 0, {req, " strobes"}, pulses, 0);
  endtask

  task automatic testReset();
    int bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (clkOut || clkEn) bad++;
    end
    rstN = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (clkOut || clkEn) bad++;
    end
    check(bad == 0, "R11 outputs low in and after reset", bad, 0);
  endtask

  task automatic testRatios();
    // src0: one edge per clk; period = edges * div
    runCase("R6 code1 div2 quarter rate", mk(1,0,0,1,2), 8, 4);
    runCase("R2 code1 div4", mk(1,0,0,1,4), 16, 8);
    runCase("R2 code2 div3 half-step", mk(1,0,0,2,3), 15, 5);
    runCase("R2 code3 div5", mk(1,0,0,3,5), 30, 12);
    runCase("R1 code2 div127", mk(1,0,0,2,127), 635, 315);
  endtask

  task automatic testSources();
    runCase("R3 source1 code2 div3", mk(1,1,0,2,3), 30, 10);
    runCase("R3 source2 code3 div2", mk(1,1,1,3,2), 36, 18);
    runCase("R3 bit13 ignored with bit14 clear", mk(1,0,1,1,2), 8, 4);
  endtask

  task automatic testLayout();
    logic [31:0] w;
    w = mk(1,0,0,2,4) | 32'hFFFF_0000 | 32'h0000_1C80;
    runCase("R4 stray bits ignored", w, 20, 10);
  endtask

  task automatic testStops();
    bit seen;
    writeCfg(mk(1,0,0,1,4));
    waitPulse(seen);
    writeCfg(mk(1,0,0,1,1));
    repeat (20) @(negedge clk);
    checkSilent("R5 divisor 1", 100);
    writeCfg(mk(1,0,0,1,3));
    waitPulse(seen);
    writeCfg(mk(1,0,0,1,0));
    repeat (20) @(negedge clk);
    checkSilent("R5 divisor 0", 100);
    writeCfg(mk(1,0,0,0,5));
    repeat (5) @(negedge clk);
    checkSilent("R7 predivider code 0", 100);
  endtask

  task automatic testDisable();
    bit seen;
    writeCfg(mk(1,0,0,3,4));
    waitPulse(seen);
    writeCfg(mk(0,0,0,3,4));
    // one old period is 24 cycles
    repeat (24) @(negedge clk);
    checkSilent("R8 enable cleared", 96);
  endtask

  task automatic testReprogram();
    bit seen; int per; int hi;
    writeCfg(mk(1,0,0,1,4));
    waitPulse(seen);
    waitPulse(seen);
    per = 0; hi = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      per++;
      if (clkOut) hi++;
      if (i == 3) begin cfgWr = 1'b1; cfgData = mk(1,1,0,2,3); end
      else begin cfgWr = 1'b0; cfgData = '0; end
      if (clkEn) break;
    end
    check(per == 16, "R9 period in progress keeps old length", per, 16);
    check(hi == 8, "R9 old high time kept", hi, 8);
    measure(per, hi);
    check(per == 30, "R9 new setting after boundary", per, 30);
    check(hi == 10, "R10 new high time", hi, 10);
  endtask

  initial begin
    testReset();
    testRatios();
    testSources();
    testLayout();
    testStops();
    testDisable();
    testReprogram();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule